// File: doc/BRIEF.md
# MSI to Adapter-Interrupt Converter

This block turns message-signalled interrupt writes into bit-level indicator updates in system memory, plus an adapter I/O interrupt request. The upper bits of each incoming MSI data word name a function and the low bits name a vector. The block presents the function number to an external routing table. The table answers in the same cycle with a hit flag, an enable flag, a 3-bit interrupt class, and the base address and bit offset of both the device indicator area and the summary indicator.

For a known, enabled function, the block issues two atomic byte OR requests to memory, one after the other. The first sets the device indicator bit and the second sets the summary bit. Each request returns the byte value from before the update. An interrupt word is emitted only when the summary byte was zero before its update, so repeated messages collapse into one interrupt until software clears the summary. Unknown functions and failed memory accesses each produce an error event. Reads of the MSI window return a fixed pattern.

Top module: `msi_ai_conv`

## Requirements
- R1: The function number is `msi_data_i[DATA_W-1:VEC_W]` and the vector is `msi_data_i[VEC_W-1:0]`. The function number appears on `route_fid_o` in the same cycle.
- R2: Bits are numbered MSB first. The indicator bit number is `ind_off + vector`. The first memory request uses byte address `ind_base + bitnum/8` (modulo 2^MADDR_W) and mask `8'h80 >> (bitnum % 8)`.
- R3: After the indicator request is acknowledged, a second request targets the summary bit. It uses the same arithmetic on `sum_base` and `sum_off` with a vector of zero. No other request comes between the two.
- R4: One cycle after the summary acknowledge, `irq_valid_o` pulses if and only if that access had no error and its old byte was `8'h00`. The word is `(class << 27) | (1 << AI_BIT)`, which puts the class in bits 29:27 and the flag in bit 31 by default.
- R5: A write whose function misses the table produces a one-cycle event with code `EVT_UNKNOWN_FN`, the function number, `msi_addr_i`, and qualifier `vector << QUAL_SHIFT`. It issues no memory request and no interrupt.
- R6: A write for a function that hits the table but is not enabled has no effect: no request, no event, no interrupt.
- R7: A read that is accepted gives `msi_rvalid_o` one cycle later, with `msi_rdata_o = 64'h0000_0000_FFFF_FFFF`, and causes no memory traffic.
- R8: An indicator access acknowledged with `mem_err_i` produces event `EVT_IND_FAIL` with zero function, address and qualifier, and the summary access still follows. A summary access with an error produces the same event and no interrupt.
- R9: `msi_ready_o` is low from the acceptance of a write until the summary acknowledge. A pending request keeps its address and mask stable until it is acknowledged.
- R10: After reset, the block is ready with no request, interrupt, event or read response active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| msi_valid_i | input | 1 | MSI access valid |
| msi_write_i | input | 1 | 1 = write, 0 = read |
| msi_data_i | input | DATA_W | MSI write data |
| msi_addr_i | input | MADDR_W | MSI target address, reported in events |
| msi_ready_o | output | 1 | Block can accept an access |
| msi_rvalid_o | output | 1 | Read response valid |
| msi_rdata_o | output | 64 | Read response data |
| route_fid_o | output | DATA_W-VEC_W | Function number for the table lookup |
| route_hit_i | input | 1 | Function exists |
| route_en_i | input | 1 | Function enabled |
| route_cls_i | input | 3 | Interrupt class |
| route_ind_base_i | input | MADDR_W | Indicator area base |
| route_ind_off_i | input | OFF_W | Indicator bit offset |
| route_sum_base_i | input | MADDR_W | Summary base |
| route_sum_off_i | input | OFF_W | Summary bit offset |
| mem_req_o | output | 1 | Atomic OR request |
| mem_addr_o | output | MADDR_W | Byte address |
| mem_mask_o | output | 8 | Bits to OR in |
| mem_ack_i | input | 1 | Request done |
| mem_err_i | input | 1 | Access failed |
| mem_old_i | input | 8 | Byte value before the OR |
| irq_valid_o | output | 1 | Interrupt request pulse |
| irq_word_o | output | 32 | Interrupt word |
| evt_valid_o | output | 1 | Error event pulse |
| evt_code_o | output | 16 | Event code |
| evt_fid_o | output | DATA_W-VEC_W | Event function number |
| evt_addr_o | output | MADDR_W | Event address |
| evt_qual_o | output | 32 | Event qualifier |

## Verification
The bench builds the block with a 6-bit vector, 12-bit offsets and a 12-bit memory address space. This lets a 4 KiB byte model cover the whole address range, including an upper error region. With those values, offsets plus vectors cross several byte boundaries, and two functions share one summary byte, so interrupts are suppressed until the bench clears that byte. Functions placed in the error region reach both failure paths, and a disabled entry and an unused function number reach the ignore path and the unknown-function path.

// File: rtl/msi_ai_pkg.sv
package msi_ai_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_IND, ST_SUM} seq_state_e;

  localparam logic [63:0] RD_PATTERN = 64'h0000_0000_FFFF_FFFF;

  // MSB-first bit select within a byte
  function automatic logic [7:0] msb_mask(input logic [2:0] pos);
    return 8'h80 >> pos;
  endfunction
endpackage

// File: rtl/msi_ai_split.sv
module msi_ai_split #(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8,
  localparam int FID_W = DATA_W - VEC_W
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [FID_W-1:0]  fid_o,
  output logic [VEC_W-1:0]  vec_o
);
  assign fid_o = data_i[DATA_W-1:VEC_W];
  assign vec_o = data_i[VEC_W-1:0];
endmodule

// File: rtl/msi_ai_locate.sv
module msi_ai_locate
  import msi_ai_pkg::*;
#(
  parameter int MADDR_W = 32,
  parameter int OFF_W   = 16,
  parameter int VEC_W   = 8,
  localparam int BITN_W = ((OFF_W > VEC_W) ? OFF_W : VEC_W) + 1
) (
  input  logic [MADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic [VEC_W-1:0]   vec_i,
  output logic [MADDR_W-1:0] addr_o,
  output logic [7:0]         mask_o
);
  logic [BITN_W-1:0]         bitn;
  logic [BITN_W-1:0]         byte_idx;
  logic [MADDR_W+BITN_W-1:0] full_addr;

  assign bitn      = {{(BITN_W-OFF_W){1'b0}}, off_i} + {{(BITN_W-VEC_W){1'b0}}, vec_i};
  assign byte_idx  = bitn >> 3;
  assign full_addr = {{BITN_W{1'b0}}, base_i} + {{MADDR_W{1'b0}}, byte_idx};
  assign addr_o    = full_addr[MADDR_W-1:0];
  assign mask_o    = msb_mask(bitn[2:0]);
endmodule

// File: rtl/msi_ai_seq.sv
module msi_ai_seq
  import msi_ai_pkg::*;
#(
  parameter int          FID_W          = 24,
  parameter int          VEC_W          = 8,
  parameter int          MADDR_W        = 32,
  parameter int          QUAL_SHIFT     = 8,
  parameter int          AI_BIT         = 31,
  parameter logic [15:0] EVT_UNKNOWN_FN = 16'h0063,
  parameter logic [15:0] EVT_IND_FAIL   = 16'h0064
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               accept_i,
  input  logic [FID_W-1:0]   fid_i,
  input  logic [VEC_W-1:0]   vec_i,
  input  logic [MADDR_W-1:0] msi_addr_i,
  input  logic               hit_i,
  input  logic               en_i,
  input  logic [2:0]         cls_i,
  input  logic [MADDR_W-1:0] ind_addr_i,
  input  logic [7:0]         ind_mask_i,
  input  logic [MADDR_W-1:0] sum_addr_i,
  input  logic [7:0]         sum_mask_i,
  output logic               idle_o,
  output logic               mem_req_o,
  output logic [MADDR_W-1:0] mem_addr_o,
  output logic [7:0]         mem_mask_o,
  input  logic               mem_ack_i,
  input  logic               mem_err_i,
  input  logic [7:0]         mem_old_i,
  output logic               irq_valid_o,
  output logic [31:0]        irq_word_o,
  output logic               evt_valid_o,
  output logic [15:0]        evt_code_o,
  output logic [FID_W-1:0]   evt_fid_o,
  output logic [MADDR_W-1:0] evt_addr_o,
  output logic [31:0]        evt_qual_o
);
  seq_state_e         state_q;
  logic [MADDR_W-1:0] ind_addr_q, sum_addr_q;
  logic [7:0]         ind_mask_q, sum_mask_q;
  logic [2:0]         cls_q;
  logic [31:0]        qual_w;
  logic [31:0]        word_w;

  assign qual_w = {{(32-VEC_W){1'b0}}, vec_i} << QUAL_SHIFT;
  assign word_w = ({29'd0, cls_q} << 27) | (32'd1 << AI_BIT);

  assign idle_o     = (state_q == ST_IDLE);
  assign mem_req_o  = (state_q != ST_IDLE);
  assign mem_addr_o = (state_q == ST_IND) ? ind_addr_q : sum_addr_q;
  assign mem_mask_o = (state_q == ST_IND) ? ind_mask_q : sum_mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      ind_addr_q  <= '0;
      sum_addr_q  <= '0;
      ind_mask_q  <= '0;
      sum_mask_q  <= '0;
      cls_q       <= '0;
      irq_valid_o <= 1'b0;
      irq_word_o  <= '0;
      evt_valid_o <= 1'b0;
      evt_code_o  <= '0;
      evt_fid_o   <= '0;
      evt_addr_o  <= '0;
      evt_qual_o  <= '0;
    end else begin
      irq_valid_o <= 1'b0;
      evt_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept_i) begin
            if (!hit_i) begin
              evt_valid_o <= 1'b1;
              evt_code_o  <= EVT_UNKNOWN_FN;
              evt_fid_o   <= fid_i;
              evt_addr_o  <= msi_addr_i;
              evt_qual_o  <= qual_w;
            end else if (en_i) begin
              ind_addr_q <= ind_addr_i;
              ind_mask_q <= ind_mask_i;
              sum_addr_q <= sum_addr_i;
              sum_mask_q <= sum_mask_i;
              cls_q      <= cls_i;
              state_q    <= ST_IND;
            end
          end
        end
        ST_IND: begin
          if (mem_ack_i) begin
            if (mem_err_i) begin
              evt_valid_o <= 1'b1;
              evt_code_o  <= EVT_IND_FAIL;
              evt_fid_o   <= '0;
              evt_addr_o  <= '0;
              evt_qual_o  <= '0;
            end
            state_q <= ST_SUM;
          end
        end
        ST_SUM: begin
          if (mem_ack_i) begin
            if (mem_err_i) begin
              evt_valid_o <= 1'b1;
              evt_code_o  <= EVT_IND_FAIL;
              evt_fid_o   <= '0;
              evt_addr_o  <= '0;
              evt_qual_o  <= '0;
            end else if (mem_old_i == 8'h00) begin
              irq_valid_o <= 1'b1;
              irq_word_o  <= word_w;
            end
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msi_ai_conv.sv
module msi_ai_conv
  import msi_ai_pkg::*;
#(
  parameter int          DATA_W         = 32,
  parameter int          VEC_W          = 8,
  parameter int          OFF_W          = 16,
  parameter int          MADDR_W        = 32,
  parameter int          QUAL_SHIFT     = 8,
  parameter int          AI_BIT         = 31,
  parameter logic [15:0] EVT_UNKNOWN_FN = 16'h0063,
  parameter logic [15:0] EVT_IND_FAIL   = 16'h0064,
  localparam int         FID_W          = DATA_W - VEC_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               msi_valid_i,
  input  logic               msi_write_i,
  input  logic [DATA_W-1:0]  msi_data_i,
  input  logic [MADDR_W-1:0] msi_addr_i,
  output logic               msi_ready_o,
  output logic               msi_rvalid_o,
  output logic [63:0]        msi_rdata_o,
  output logic [FID_W-1:0]   route_fid_o,
  input  logic               route_hit_i,
  input  logic               route_en_i,
  input  logic [2:0]         route_cls_i,
  input  logic [MADDR_W-1:0] route_ind_base_i,
  input  logic [OFF_W-1:0]   route_ind_off_i,
  input  logic [MADDR_W-1:0] route_sum_base_i,
  input  logic [OFF_W-1:0]   route_sum_off_i,
  output logic               mem_req_o,
  output logic [MADDR_W-1:0] mem_addr_o,
  output logic [7:0]         mem_mask_o,
  input  logic               mem_ack_i,
  input  logic               mem_err_i,
  input  logic [7:0]         mem_old_i,
  output logic               irq_valid_o,
  output logic [31:0]        irq_word_o,
  output logic               evt_valid_o,
  output logic [15:0]        evt_code_o,
  output logic [FID_W-1:0]   evt_fid_o,
  output logic [MADDR_W-1:0] evt_addr_o,
  output logic [31:0]        evt_qual_o
);
  localparam int N_LOC = 2;  // 0: device indicator, 1: summary

  logic [VEC_W-1:0]              vec;
  logic                          idle;
  logic                          wr_accept, rd_accept;
  logic                          rvalid_q;
  logic [N_LOC-1:0][MADDR_W-1:0] loc_base, loc_addr;
  logic [N_LOC-1:0][OFF_W-1:0]   loc_off;
  logic [N_LOC-1:0][VEC_W-1:0]   loc_vec;
  logic [N_LOC-1:0][7:0]         loc_mask;

  msi_ai_split #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_split (
    .data_i (msi_data_i),
    .fid_o  (route_fid_o),
    .vec_o  (vec)
  );

  assign loc_base[0] = route_ind_base_i;
  assign loc_off[0]  = route_ind_off_i;
  assign loc_vec[0]  = vec;
  assign loc_base[1] = route_sum_base_i;
  assign loc_off[1]  = route_sum_off_i;
  assign loc_vec[1]  = '0;

  for (genvar g = 0; g < N_LOC; g++) begin : g_loc
    msi_ai_locate #(.MADDR_W(MADDR_W), .OFF_W(OFF_W), .VEC_W(VEC_W)) u_loc (
      .base_i (loc_base[g]),
      .off_i  (loc_off[g]),
      .vec_i  (loc_vec[g]),
      .addr_o (loc_addr[g]),
      .mask_o (loc_mask[g])
    );
  end

  assign msi_ready_o = idle;
  assign wr_accept   = msi_valid_i && msi_write_i && idle;
  assign rd_accept   = msi_valid_i && !msi_write_i && idle;

  msi_ai_seq #(
    .FID_W(FID_W), .VEC_W(VEC_W), .MADDR_W(MADDR_W), .QUAL_SHIFT(QUAL_SHIFT),
    .AI_BIT(AI_BIT), .EVT_UNKNOWN_FN(EVT_UNKNOWN_FN), .EVT_IND_FAIL(EVT_IND_FAIL)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (wr_accept),
    .fid_i       (route_fid_o),
    .vec_i       (vec),
    .msi_addr_i  (msi_addr_i),
    .hit_i       (route_hit_i),
    .en_i        (route_en_i),
    .cls_i       (route_cls_i),
    .ind_addr_i  (loc_addr[0]),
    .ind_mask_i  (loc_mask[0]),
    .sum_addr_i  (loc_addr[1]),
    .sum_mask_i  (loc_mask[1]),
    .idle_o      (idle),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_mask_o  (mem_mask_o),
    .mem_ack_i   (mem_ack_i),
    .mem_err_i   (mem_err_i),
    .mem_old_i   (mem_old_i),
    .irq_valid_o (irq_valid_o),
    .irq_word_o  (irq_word_o),
    .evt_valid_o (evt_valid_o),
    .evt_code_o  (evt_code_o),
    .evt_fid_o   (evt_fid_o),
    .evt_addr_o  (evt_addr_o),
    .evt_qual_o  (evt_qual_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rvalid_q <= 1'b0;
    else         rvalid_q <= rd_accept;
  end

  assign msi_rvalid_o = rvalid_q;
  assign msi_rdata_o  = rvalid_q ? RD_PATTERN : 64'd0;
endmodule

// File: rtl/msi_ai_conv_chk.sv
module msi_ai_conv_chk #(
  parameter int MADDR_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               msi_valid_i,
  input logic               msi_write_i,
  input logic               msi_ready_o,
  input logic               msi_rvalid_o,
  input logic               mem_req_o,
  input logic [MADDR_W-1:0] mem_addr_o,
  input logic [7:0]         mem_mask_o,
  input logic               mem_ack_i,
  input logic               mem_err_i,
  input logic [7:0]         mem_old_i,
  input logic               irq_valid_o
);
  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_mask_o)));

  // R9
  busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !msi_ready_o);

  // R4
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> $past(mem_req_o && mem_ack_i && !mem_err_i && (mem_old_i == 8'h00)));

  // R7
  rd_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_rvalid_o |-> $past(msi_valid_i && !msi_write_i && msi_ready_o));

  // R2
  mask_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> ($countones(mem_mask_o) == 1));
endmodule

bind msi_ai_conv msi_ai_conv_chk #(.MADDR_W(MADDR_W)) u_chk (.*);

// File: tb/msi_ai_conv_bench.sv
module msi_ai_conv_bench;
  localparam int DATA_W = 32, VEC_W = 6, OFF_W = 12, MADDR_W = 12;
  localparam int QUAL_SHIFT = 4, AI_BIT = 31;
  localparam int FID_W = DATA_W - VEC_W;
  localparam logic [15:0] C_UNK = 16'h0063, C_FAIL = 16'h0064;
  localparam int BAD_LO = 12'hF00;
  localparam int NENT = 6;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic msi_valid = 0, msi_write = 0;
  logic [DATA_W-1:0] msi_data = '0;
  logic [MADDR_W-1:0] msi_addr = '0;
  logic msi_ready, msi_rvalid;
  logic [63:0] msi_rdata;
  logic [FID_W-1:0] route_fid;
  logic r_hit, r_en;
  logic [2:0] r_cls;
  logic [MADDR_W-1:0] r_ib, r_sb;
  logic [OFF_W-1:0] r_io, r_so;
  logic mem_req, mem_ack = 0, mem_err = 0;
  logic [MADDR_W-1:0] mem_addr;
  logic [7:0] mem_mask, mem_old = 0;
  logic irq_valid, evt_valid;
  logic [31:0] irq_word, evt_qual;
  logic [15:0] evt_code;
  logic [FID_W-1:0] evt_fid;
  logic [MADDR_W-1:0] evt_addr;

  msi_ai_conv #(.DATA_W(DATA_W), .VEC_W(VEC_W), .OFF_W(OFF_W), .MADDR_W(MADDR_W),
                .QUAL_SHIFT(QUAL_SHIFT), .AI_BIT(AI_BIT)) u_msi_ai_conv (
    .clk_i(clk), .rst_ni(rst_n), .msi_valid_i(msi_valid), .msi_write_i(msi_write),
    .msi_data_i(msi_data), .msi_addr_i(msi_addr), .msi_ready_o(msi_ready),
    .msi_rvalid_o(msi_rvalid), .msi_rdata_o(msi_rdata), .route_fid_o(route_fid),
    .route_hit_i(r_hit), .route_en_i(r_en), .route_cls_i(r_cls),
    .route_ind_base_i(r_ib), .route_ind_off_i(r_io), .route_sum_base_i(r_sb),
    .route_sum_off_i(r_so), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_mask_o(mem_mask), .mem_ack_i(mem_ack), .mem_err_i(mem_err), .mem_old_i(mem_old),
    .irq_valid_o(irq_valid), .irq_word_o(irq_word), .evt_valid_o(evt_valid),
    .evt_code_o(evt_code), .evt_fid_o(evt_fid), .evt_addr_o(evt_addr), .evt_qual_o(evt_qual));

  // routing table (entry 2 disabled; 0 and 1 share a summary byte)
  int t_fid [NENT] = '{5, 9, 17, 33, 41, 63};
  bit t_en  [NENT] = '{1, 1, 0, 1, 1, 1};
  int t_cls [NENT] = '{3, 6, 5, 1, 2, 7};
  int t_ib  [NENT] = '{'h100, 'h200, 'h280, 'hF80, 'h300, 'h3F0};
  int t_io  [NENT] = '{3, 13, 0, 0, 60, 100};
  int t_sb  [NENT] = '{'h040, 'h040, 'h048, 'h050, 'hF10, 'h060};
  int t_so  [NENT] = '{0, 1, 2, 7, 2, 4};

  always_comb begin
    r_hit = 0; r_en = 0; r_cls = '0; r_ib = '0; r_io = '0; r_sb = '0; r_so = '0;
    for (int i = 0; i < NENT; i++) begin
      if (route_fid == FID_W'(t_fid[i])) begin
        r_hit = 1; r_en = t_en[i]; r_cls = 3'(t_cls[i]);
        r_ib = MADDR_W'(t_ib[i]); r_io = OFF_W'(t_io[i]);
        r_sb = MADDR_W'(t_sb[i]); r_so = OFF_W'(t_so[i]);
      end
    end
  end

  // memory model with atomic OR
  logic [7:0] mem [0:4095];
  int dly = 0;
  int n_req = 0;
  logic [MADDR_W-1:0] req_addr [0:3];
  logic [7:0] req_mask [0:3];
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 0;
    else if (mem_req) begin
      if (dly == 0) begin
        if (n_req < 4) begin req_addr[n_req] = mem_addr; req_mask[n_req] = mem_mask; end
        n_req++;
        mem_err = (int'(mem_addr) >= BAD_LO);
        mem_old = mem_err ? 8'h5A : mem[mem_addr];
        if (!mem_err) mem[mem_addr] = mem[mem_addr] | mem_mask;
        mem_ack = 1;
        dly = $urandom % 3;
      end else dly--;
    end
  end

  int n_irq = 0, n_evt = 0;
  logic [31:0] last_irq;
  logic [15:0] last_code;
  logic [FID_W-1:0] last_efid;
  logic [MADDR_W-1:0] last_eaddr;
  logic [31:0] last_qual;
  always @(negedge clk) begin
    if (irq_valid) begin n_irq++; last_irq = irq_word; end
    if (evt_valid) begin
      n_evt++; last_code = evt_code; last_efid = evt_fid;
      last_eaddr = evt_addr; last_qual = evt_qual;
    end
  end

  int total = 0, bad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [MADDR_W-1:0] e_addr(input int base, input int off, input int v);
    return MADDR_W'(base + (off + v) / 8);
  endfunction
  function automatic logic [7:0] e_mask(input int off, input int v);
    return 8'h80 >> ((off + v) % 8);
  endfunction

  task automatic send_write(input int fid, input int v);
    int idx = -1;
    logic [MADDR_W-1:0] ia, sa;
    logic [7:0] im, sm, old_s;
    bit ie, se, exp_irq;
    int exp_evt;
    logic [MADDR_W-1:0] ma;
    for (int i = 0; i < NENT; i++) if (t_fid[i] == fid) idx = i;
    ma = MADDR_W'($urandom);
    n_req = 0; n_irq = 0; n_evt = 0;
    ia = '0; sa = '0; im = '0; sm = '0; ie = 0; se = 0; exp_irq = 0; exp_evt = 0;
    if (idx >= 0 && t_en[idx]) begin
      ia = e_addr(t_ib[idx], t_io[idx], v); im = e_mask(t_io[idx], v);
      sa = e_addr(t_sb[idx], t_so[idx], 0); sm = e_mask(t_so[idx], 0);
      ie = (int'(ia) >= BAD_LO); se = (int'(sa) >= BAD_LO);
      old_s = mem[sa];
      if (!ie && ia == sa) old_s = old_s | im;
      exp_irq = !se && (old_s == 8'h00);
      exp_evt = int'(ie) + int'(se);
    end else if (idx < 0) exp_evt = 1;
    @(negedge clk);
    msi_valid = 1; msi_write = 1; msi_data = {FID_W'(fid), VEC_W'(v)}; msi_addr = ma;
    #1;
    check(route_fid == FID_W'(fid), "R1 fid", 64'(route_fid), 64'(fid));
    @(negedge clk);
    msi_valid = 0;
    if (idx >= 0 && t_en[idx]) check(!msi_ready, "R9 busy", 64'(msi_ready), 0);
    repeat (20) @(negedge clk);
    if (idx >= 0 && t_en[idx]) begin
      check(n_req == 2, "R3 request count", 64'(n_req), 2);
      check(req_addr[0] == ia && req_mask[0] == im, "R2 indicator",
            {req_addr[0], req_mask[0]}, {ia, im});
      check(req_addr[1] == sa && req_mask[1] == sm, "R3 summary",
            {req_addr[1], req_mask[1]}, {sa, sm});
      check(n_irq == int'(exp_irq), "R4 irq count", 64'(n_irq), 64'(exp_irq));
      if (exp_irq)
        check(last_irq == ((32'(t_cls[idx]) << 27) | 32'h8000_0000), "R4 irq word",
              64'(last_irq), 64'((32'(t_cls[idx]) << 27) | 32'h8000_0000));
      check(n_evt == exp_evt, "R8 event count", 64'(n_evt), 64'(exp_evt));
      if (exp_evt > 0)
        check(last_code == C_FAIL && last_efid == 0 && last_eaddr == 0 && last_qual == 0,
              "R8 event fields", 64'(last_code), 64'(C_FAIL));
    end else if (idx >= 0) begin
      check(n_req == 0 && n_evt == 0 && n_irq == 0 && msi_ready, "R6 ignored",
            64'(n_req + n_evt + n_irq), 0);
    end else begin
      check(n_req == 0 && n_irq == 0, "R5 no traffic", 64'(n_req + n_irq), 0);
      check(n_evt == 1 && last_code == C_UNK, "R5 code", 64'(last_code), 64'(C_UNK));
      check(last_efid == FID_W'(fid) && last_eaddr == ma, "R5 fid/addr",
            {last_efid, last_eaddr}, {FID_W'(fid), ma});
      check(last_qual == (32'(v) << QUAL_SHIFT), "R5 qualifier",
            64'(last_qual), 64'(32'(v) << QUAL_SHIFT));
    end
    check(msi_ready, "R9 ready after", 64'(msi_ready), 1);
  endtask

  task automatic do_read();
    n_req = 0;
    @(negedge clk);
    msi_valid = 1; msi_write = 0; msi_data = $urandom;
    @(negedge clk);
    msi_valid = 0;
    check(msi_rvalid && msi_rdata == 64'h0000_0000_FFFF_FFFF, "R7 read data",
          msi_rdata, 64'h0000_0000_FFFF_FFFF);
    @(negedge clk);
    check(!msi_rvalid && n_req == 0, "R7 single response", 64'(msi_rvalid), 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    check(msi_ready && !mem_req && !irq_valid && !evt_valid && !msi_rvalid, "R10 reset",
          {msi_ready, mem_req, irq_valid, evt_valid, msi_rvalid}, 5'b10000);
    rst_n = 1;
    @(negedge clk);
    check(msi_ready && !mem_req, "R10 idle after release", 64'(msi_ready), 1);
    // directed corners
    send_write(5, 0);      // first summary set: irq
    send_write(9, 7);      // shared summary already set: no irq
    mem[12'h040] = 8'h00;
    send_write(9, 63);     // cleared summary: irq again
    send_write(17, 4);     // disabled
    send_write(77, 45);    // unknown
    send_write(33, 2);     // indicator error, summary still done
    send_write(41, 9);     // summary error, no irq
    send_write(63, 63);    // byte-boundary crossing
    do_read();
    // random mix
    for (int k = 0; k < 200; k++) begin
      int pick = $urandom % (NENT + 1);
      int f = (pick == NENT) ? 100 + ($urandom % 50) : t_fid[pick];
      if ($urandom % 2) mem[t_sb[$urandom % NENT] % 4096] = 8'h00;
      if ($urandom % 10 == 0) do_read();
      send_write(f, $urandom % 64);
    end
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule